// File: doc/BRIEF.md
# Dual-Width Code-Group Serializer

This block turns already-encoded 10-bit code groups into a single serial line. A parallel word on a 20-bit bus carries either one code group (narrow mode) or two code groups back to back (wide mode). A static select input picks the mode. In narrow mode only the upper ten bus lines carry data. The block runs on the fast bit clock. It owns the word-boundary divider and raises a one-cycle load strobe. The upstream reference-clock logic must present the next word on the bus while that strobe is high.

In narrow mode a word lasts ten bit clocks, and in wide mode twenty. Because the reference clock runs twice as fast in narrow mode, the line rate is the same in both modes. Bits leave in ascending bus order starting at the lowest line that holds data: line 10 in narrow mode, line 0 in wide mode. Within each group the lowest line is code bit a. The next word follows the last bit of the previous one with no idle bit in between. The output enable forces the line to 0 without disturbing the internal word timing.

Top module: `ser_top`

## Requirements
- R1: `ld_stb_o` is high for exactly one bit-clock cycle per word. It repeats every 10 cycles when the loaded word is narrow and every 20 cycles when it is wide. `din_i` and `wsel_i` are captured at the rising edge that ends the strobe cycle.
- R2: With `wsel_i`=1 (narrow) at capture, `sout_o` carries `din_i[10]` in the first cycle after the capture edge, then `din_i[11]` through `din_i[19]` in the next nine cycles.
- R3: In narrow mode, the values on `din_i[9:0]` have no effect on `sout_o`.
- R4: With `wsel_i`=0 (wide) at capture, `sout_o` carries `din_i[0]` in the first cycle after the capture edge, then `din_i[1]` through `din_i[19]` in the next nineteen cycles.
- R5: The first bit of a word appears in the cycle right after the last bit of the previous word, with no gap cycle.
- R6: While `oe_i`=0, `sout_o` is 0. Shifting and the strobe period go on unchanged, so a word that starts after `oe_i` returns is aligned and correct.
- R7: Driving `rst_ni` low clears the shift register and the bit counter at once: `sout_o`=0 and `ld_stb_o`=0. Release passes through a two-stage synchronizer. The first strobe is high in the cycle after the second rising edge following release.
- R8: `wsel_i` is sampled only at the capture edge. A change in the middle of a word alters neither that word's length nor its bits, and it takes effect at the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din_i | input | 20 | Parallel code-group word; narrow mode uses bits 19:10 |
| wsel_i | input | 1 | Width select: 1 = one 10-bit group, 0 = two groups (20 bits) |
| oe_i | input | 1 | Output enable; 0 forces `sout_o` low |
| ld_stb_o | output | 1 | Word-boundary strobe; the word on `din_i` is taken at the end of this cycle |
| sout_o | output | 1 | Serial data, one bit per clock |

## Verification
A capture happens at the rising edge that closes a strobe cycle. Bit k of that word is due on `sout_o` in the (k+1)-th cycle after that edge. The next strobe is due in the same cycle as the last bit. After reset release, the first strobe is due two edges later. The bench drives and samples only at falling edges, so each expected bit is compared in exactly the cycle it is due. On every bit of every word, the bench also checks that the strobe is high in the last bit cycle and low in every other one.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } ser_mode_e;

endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign srst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ser_word_pack.sv
module ser_word_pack
  import ser_pkg::*;
#(
  parameter int GRP_W = 10,
  parameter int NGRP  = 2,
  localparam int BUS_W = GRP_W * NGRP,
  localparam int CNT_W = $clog2(BUS_W)
) (
  input  logic [BUS_W-1:0] din_i,
  input  ser_mode_e        mode_i,
  output logic [BUS_W-1:0] word_o,
  output logic [CNT_W-1:0] last_idx_o
);

  logic narrow;
  assign narrow = (mode_i == MODE_NARROW);

  // Group 0 of the packed word is sent first; narrow mode moves the top group there.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == 0) begin : g_first
      assign word_o[GRP_W-1:0] = narrow ? din_i[BUS_W-1 -: GRP_W]
                                        : din_i[GRP_W-1:0];
    end else begin : g_rest
      assign word_o[g*GRP_W +: GRP_W] = narrow ? '0 : din_i[g*GRP_W +: GRP_W];
    end
  end

  assign last_idx_o = narrow ? CNT_W'(GRP_W - 1) : CNT_W'(BUS_W - 1);

endmodule

// File: rtl/ser_bit_ctr.sv
module ser_bit_ctr #(
  parameter int BUS_W = 20,
  localparam int CNT_W = $clog2(BUS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] last_idx_i,
  output logic             stb_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign stb_o  = rst_ni && (cnt_q == '0);
  assign cnt_en = rst_ni;

  always_comb begin
    cnt_d = cnt_q;
    if (stb_o)              cnt_d = last_idx_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o); // R1
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_o |-> (cnt_q < CNT_W'(BUS_W))); // R1

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int BUS_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BUS_W-1:0] word_i,
  output logic             bit_o
);

  logic [BUS_W-1:0] sh_q;
  logic [BUS_W-1:0] sh_d;
  logic             sh_en;

  assign sh_en = rst_ni;

  always_comb begin
    if (load_i) sh_d = word_i;
    else        sh_d = {1'b0, sh_q[BUS_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/ser_top.sv
module ser_top
  import ser_pkg::*;
#(
  parameter int GRP_W = 10,
  parameter int NGRP  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W = GRP_W * NGRP,
  localparam int CNT_W = $clog2(BUS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] din_i,
  input  logic             wsel_i,
  input  logic             oe_i,
  output logic             ld_stb_o,
  output logic             sout_o
);

  logic             srst_n;
  logic [BUS_W-1:0] word;
  logic [CNT_W-1:0] last_idx;
  logic             stb;
  logic             line_bit;
  ser_mode_e        mode;

  assign mode = ser_mode_e'(wsel_i);

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  ser_word_pack #(.GRP_W(GRP_W), .NGRP(NGRP)) u_pack (
    .din_i      (din_i),
    .mode_i     (mode),
    .word_o     (word),
    .last_idx_o (last_idx)
  );

  ser_bit_ctr #(.BUS_W(BUS_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (srst_n),
    .last_idx_i (last_idx),
    .stb_o      (stb)
  );

  ser_shifter #(.BUS_W(BUS_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (srst_n),
    .load_i (stb),
    .word_i (word),
    .bit_o  (line_bit)
  );

  assign ld_stb_o = stb;
  assign sout_o   = line_bit & oe_i;

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_n |-> !ld_stb_o); // R7
  AST_FIRST_NARROW: assert property (@(posedge clk_i) disable iff (!srst_n)
    (ld_stb_o && wsel_i) |=> (!oe_i || sout_o == $past(din_i[BUS_W-GRP_W]))); // R2
  AST_FIRST_WIDE: assert property (@(posedge clk_i) disable iff (!srst_n)
    (ld_stb_o && !wsel_i) |=> (!oe_i || sout_o == $past(din_i[0]))); // R4

endmodule

// File: tb/ser_top_tb_top.sv
`timescale 1ns/1ps
module ser_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [19:0] din;
  logic        wsel;
  logic        oe;
  logic        stb;
  logic        sout;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1ace_b00c;

  ser_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .wsel_i(wsel),
    .oe_i(oe), .ld_stb_o(stb), .sout_o(sout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at the falling edge of a strobe cycle; leaves at the falling edge of the word's last bit.
  task automatic send_word(logic [19:0] w, logic ws, logic en, bit flip_mid);
    int len;
    logic exp_bit;
    len = ws ? 10 : 20;
    din = w; wsel = ws; oe = en;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      exp_bit = en ? (ws ? w[10+i] : w[i]) : 1'b0;
      if (ws) check(sout === exp_bit, "R2 R3 narrow bit", int'(sout), int'(exp_bit));
      else    check(sout === exp_bit, "R4 wide bit", int'(sout), int'(exp_bit));
      if (i == len - 1) check(stb === 1'b1, "R1 R5 strobe at last bit", int'(stb), 1);
      else              check(stb === 1'b0, "R1 strobe idle mid-word", int'(stb), 0);
      if (flip_mid && i == 2) begin
        wsel = ~ws;         // R8: mid-word change must not alter this word
        din  = rnd();
      end
      if (flip_mid && i == len - 1) wsel = ws;
    end
  endtask

  task automatic reset_seq();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sout === 1'b0, "R7 sout in reset", int'(sout), 0);
    check(stb === 1'b0, "R7 strobe in reset", int'(stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stb === 1'b0, "R7 no strobe after one edge", int'(stb), 0);
    @(negedge clk);
    check(stb === 1'b1, "R7 first strobe after two edges", int'(stb), 1);
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; din = '0; wsel = 1'b1; oe = 1'b1;
    reset_seq();

    // R2 R3: every narrow code group, lower bus half random
    for (int c = 0; c < 1024; c++) begin
      r = rnd();
      send_word({c[9:0], r[9:0]}, 1'b1, 1'b1, 1'b0);
    end

    // R4: wide words, random
    for (int k = 0; k < 300; k++) send_word(rnd(), 1'b0, 1'b1, 1'b0);

    // R5 R8: mixed widths back to back with mid-word select flips
    for (int k = 0; k < 200; k++) begin
      r = rnd();
      send_word(rnd(), r[0], 1'b1, 1'b1);
    end

    // R6: disabled words, then enabled words must stay aligned
    for (int k = 0; k < 20; k++) begin
      r = rnd();
      send_word(rnd(), r[1], 1'b0, 1'b0);
    end
    for (int k = 0; k < 20; k++) begin
      r = rnd();
      send_word(rnd(), r[1], 1'b1, 1'b0);
    end

    // R7: reset in the middle of a word
    din = 20'hfffff; wsel = 1'b0; oe = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check(sout === 1'b0, "R7 sout clears at once", int'(sout), 0);
    check(stb === 1'b0, "R7 strobe clears at once", int'(stb), 0);
    @(negedge clk);
    reset_seq();
    send_word(20'h003ff, 1'b0, 1'b1, 1'b0);
    send_word(20'h5a5a5, 1'b1, 1'b1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule